// File: doc/BRIEF.md
# Serial Audio Slot Receiver

This block turns a serial audio stream into parallel words. An external bit clock, a frame sync line and a data line come in from a codec-style link. The block brings them into the system clock domain and samples the data whenever the bit clock falls. It also tracks frames and time slots and hands each finished word to a downstream consumer over a valid/ready pair. Each word carries the index of the slot it came from. A receive FIFO or DMA engine sits behind that handshake.

The block has two framing modes. In the single-word mode, one word is taken right after each frame sync. Every bit clock after that word, up to the next frame sync, is ignored, so a frame can be much longer than its word. In the multi-slot mode, up to four back-to-back slots follow the frame sync. A mask chooses which of these slots are kept. Words are 8 or 16 bits long and are shifted in most significant bit first. Mode, word length and mask are captured when a frame begins and stay in force for that whole frame.

Top module: `pcm_tdm_rx`

## Requirements
- R1: While reset is asserted and right after it, `rx_valid_o` and `overrun_o` are 0.
- R2: Data and frame sync are sampled only on falling edges of `bclk_i`. The bit that completes a word makes `rx_valid_o` rise `SYNC_STAGES`+1 system clock edges after the clock edge following which `bclk_i` went low.
- R3: A frame starts only at a falling bit-clock edge where `fsync_i` is seen high after being seen low at the previous falling edge. Nothing is captured before the first such start, and the bit sampled at the start is the first bit of slot 0.
- R4: Bits are assembled most significant bit first. An 8-bit word sits in `rx_data_o[7:0]`, with bits 15:8 set to zero.
- R5: `word16_i`=1 selects 16-bit words and `word16_i`=0 selects 8-bit words.
- R6: With `net_mode_i`=0, exactly one word per frame is delivered, with slot index 0. Later bits in the frame are dropped and `slot_en_i` has no effect.
- R7: With `net_mode_i`=1, four consecutive word-length slots follow the frame start. They are delivered with slot indices 0, 1, 2, 3 in that order.
- R8: In the multi-slot mode, a slot whose bit in `slot_en_i` (bit n for slot n) is 0 still takes up its bit times, but its word is not delivered.
- R9: A new frame start that comes before a word is complete throws away the partial word. Reception restarts at slot 0.
- R10: When a word completes while `rx_valid_o`=1 and `rx_ready_i`=0, the new word is dropped and `overrun_o` is 1 for exactly one cycle. That cycle is the one in which the word would otherwise have been presented.
- R11: While `rx_valid_o`=1 and `rx_ready_i`=0, `rx_valid_o`, `rx_data_o` and `rx_slot_o` hold their values. The word leaves on the first edge with `rx_ready_i`=1.
- R12: Mode, word length and slot mask are taken at the frame start. Changes during a frame take effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External serial bit clock (asynchronous) |
| fsync_i | input | 1 | Frame sync (asynchronous) |
| sdata_i | input | 1 | Serial receive data (asynchronous) |
| net_mode_i | input | 1 | 1 = multi-slot frames, 0 = one word per frame |
| word16_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| slot_en_i | input | 4 | Per-slot capture mask for multi-slot mode |
| rx_valid_o | output | 1 | Word available |
| rx_ready_i | input | 1 | Consumer accepts the word |
| rx_data_o | output | 16 | Received word, right aligned |
| rx_slot_o | output | 2 | Slot index of the word |
| overrun_o | output | 1 | One-cycle pulse when a completed word is dropped |

## Verification
A completed word, and any overrun pulse it causes, is due `SYNC_STAGES`+1 = 3 system clock edges after the edge following which the bench drives the bit clock low. Releasing a held word takes one edge with ready high. The bench model records each expected word with its due cycle number at the moment it drives the falling bit clock. On every clock it updates its expected output register and compares valid, data, slot and overrun at the falling system clock edge. Because of this, a word that arrives one cycle early or late fails the check. Per-section word counts and last-word values back up the cycle-by-cycle comparison.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic {
    FR_IDLE   = 1'b0,
    FR_ACTIVE = 1'b1
  } fr_state_e;

  // Number of bits in a word for the chosen length.
  function automatic int unsigned word_len(input logic w16,
                                           input int unsigned short_len,
                                           input int unsigned long_len);
    return w16 ? long_len : short_len;
  endfunction

  // Number of slots that make up one frame.
  function automatic int unsigned slot_count(input logic net,
                                             input int unsigned max_slots);
    return net ? max_slots : 1;
  endfunction

  // Whether a slot's word is delivered.
  function automatic logic slot_enabled(input logic net,
                                        input logic [31:0] mask,
                                        input int unsigned slot);
    return net ? mask[slot] : (slot == 0);
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] st_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          st_q <= '0;
        end else begin
          st_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
      end
      assign q_o = st_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pcm_rx_bitedge.sv
module pcm_rx_bitedge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_s_i,
  output logic bit_fall_o
);
  logic bclk_d_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) bclk_d_q <= 1'b0;
    else         bclk_d_q <= bclk_s_i;
  end

  assign bit_fall_o = bclk_d_q & ~bclk_s_i;
endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
  import pcm_rx_pkg::*;
#(
  parameter int MAX_SLOTS = 4,
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 8,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BIT_W    = $clog2(LONG_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_fall_i,
  input  logic                 fs_i,
  input  logic                 sd_i,
  input  logic                 net_mode_i,
  input  logic                 word16_i,
  input  logic [MAX_SLOTS-1:0] slot_en_i,
  output logic                 frame_start_o,
  output logic                 word_done_o,
  output logic                 word_keep_o,
  output logic [LONG_LEN-1:0]  word_data_o,
  output logic [SLOT_W-1:0]    word_slot_o,
  output logic                 net_q_o,
  output logic                 w16_q_o,
  output logic [MAX_SLOTS-1:0] en_q_o
);
  localparam logic [LONG_LEN-1:0] LOW_MASK = LONG_LEN'((1 << SHORT_LEN) - 1);

  fr_state_e             state_q;
  logic                  fs_prev_q;
  logic [BIT_W-1:0]      bit_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [LONG_LEN-1:0]   shift_q;
  logic                  net_q, w16_q;
  logic [MAX_SLOTS-1:0]  en_q;

  logic                  last_bit, last_slot;
  logic [LONG_LEN-1:0]   shift_nxt;

  assign frame_start_o = bit_fall_i & fs_i & ~fs_prev_q;
  assign shift_nxt     = {shift_q[LONG_LEN-2:0], sd_i};
  assign last_bit      = (32'(bit_q) == word_len(w16_q, SHORT_LEN, LONG_LEN) - 1);
  assign last_slot     = (32'(slot_q) == slot_count(net_q, MAX_SLOTS) - 1);

  assign word_done_o = bit_fall_i & ~frame_start_o & (state_q == FR_ACTIVE) & last_bit;
  assign word_keep_o = word_done_o & slot_enabled(net_q, 32'(en_q), 32'(slot_q));
  assign word_data_o = w16_q ? shift_nxt : (shift_nxt & LOW_MASK);
  assign word_slot_o = slot_q;

  assign net_q_o = net_q;
  assign w16_q_o = w16_q;
  assign en_q_o  = en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= FR_IDLE;
      fs_prev_q <= 1'b1;
      bit_q     <= '0;
      slot_q    <= '0;
      shift_q   <= '0;
      net_q     <= 1'b0;
      w16_q     <= 1'b0;
      en_q      <= '0;
    end else if (bit_fall_i) begin
      fs_prev_q <= fs_i;
      if (frame_start_o) begin
        state_q <= FR_ACTIVE;
        bit_q   <= BIT_W'(1);
        slot_q  <= '0;
        shift_q <= LONG_LEN'(sd_i);
        net_q   <= net_mode_i;
        w16_q   <= word16_i;
        en_q    <= slot_en_i;
      end else if (state_q == FR_ACTIVE) begin
        shift_q <= shift_nxt;
        if (last_bit) begin
          bit_q <= '0;
          if (last_slot) state_q <= FR_IDLE;
          else           slot_q  <= slot_q + SLOT_W'(1);
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_outbuf.sv
module pcm_rx_outbuf #(
  parameter int DATA_W = 16,
  parameter int SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              overrun_o
);
  logic room;
  assign room = ~valid_o | ready_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      slot_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= 1'b0;
      if (load_i && room) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        slot_o  <= slot_i;
      end else if (load_i) begin
        overrun_o <= 1'b1;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tdm_rx.sv
module pcm_tdm_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_SLOTS   = 4,
  parameter int LONG_LEN    = 16,
  parameter int SHORT_LEN   = 8,
  localparam int SLOT_W     = $clog2(MAX_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bclk_i,
  input  logic                 fsync_i,
  input  logic                 sdata_i,
  input  logic                 net_mode_i,
  input  logic                 word16_i,
  input  logic [MAX_SLOTS-1:0] slot_en_i,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  output logic [LONG_LEN-1:0]  rx_data_o,
  output logic [SLOT_W-1:0]    rx_slot_o,
  output logic                 overrun_o
);
  logic [2:0]           pins_s;
  logic                 bit_fall;
  logic                 frame_start, word_done, word_keep;
  logic [LONG_LEN-1:0]  word_data;
  logic [SLOT_W-1:0]    word_slot;
  logic                 net_q, w16_q;
  logic [MAX_SLOTS-1:0] en_q;

  pcm_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bclk_i, fsync_i, sdata_i}),
    .q_o   (pins_s)
  );

  pcm_rx_bitedge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclk_s_i  (pins_s[2]),
    .bit_fall_o(bit_fall)
  );

  pcm_rx_framer #(
    .MAX_SLOTS(MAX_SLOTS), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)
  ) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_fall_i   (bit_fall),
    .fs_i         (pins_s[1]),
    .sd_i         (pins_s[0]),
    .net_mode_i   (net_mode_i),
    .word16_i     (word16_i),
    .slot_en_i    (slot_en_i),
    .frame_start_o(frame_start),
    .word_done_o  (word_done),
    .word_keep_o  (word_keep),
    .word_data_o  (word_data),
    .word_slot_o  (word_slot),
    .net_q_o      (net_q),
    .w16_q_o      (w16_q),
    .en_q_o       (en_q)
  );

  pcm_rx_outbuf #(.DATA_W(LONG_LEN), .SLOT_W(SLOT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (word_keep),
    .data_i   (word_data),
    .slot_i   (word_slot),
    .ready_i  (rx_ready_i),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .slot_o   (rx_slot_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/pcm_tdm_rx_chk.sv
module pcm_tdm_rx_chk #(
  parameter int MAX_SLOTS = 4,
  parameter int LONG_LEN  = 16,
  parameter int SHORT_LEN = 8,
  parameter int SLOT_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_valid_o,
  input logic                 rx_ready_i,
  input logic [LONG_LEN-1:0]  rx_data_o,
  input logic [SLOT_W-1:0]    rx_slot_o,
  input logic                 overrun_o,
  input logic                 bit_fall,
  input logic                 frame_start,
  input logic                 word_done,
  input logic                 word_keep,
  input logic [LONG_LEN-1:0]  word_data,
  input logic [SLOT_W-1:0]    word_slot,
  input logic                 net_q,
  input logic                 w16_q,
  input logic [MAX_SLOTS-1:0] en_q
);
  assert_word_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done || frame_start) |-> bit_fall);

  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_keep && !w16_q) |-> ((word_data >> SHORT_LEN) == '0));

  assert_single_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_keep && !net_q) |-> (word_slot == '0));

  assert_load_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(word_keep));

  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_keep && net_q) |-> en_q[word_slot]);

  assert_overrun_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> (rx_valid_o && $past(word_keep && rx_valid_o && !rx_ready_i)));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && $stable(rx_slot_o)));
endmodule

bind pcm_tdm_rx pcm_tdm_rx_chk #(
  .MAX_SLOTS(MAX_SLOTS), .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .SLOT_W(SLOT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_data_o  (rx_data_o),
  .rx_slot_o  (rx_slot_o),
  .overrun_o  (overrun_o),
  .bit_fall   (bit_fall),
  .frame_start(frame_start),
  .word_done  (word_done),
  .word_keep  (word_keep),
  .word_data  (word_data),
  .word_slot  (word_slot),
  .net_q      (net_q),
  .w16_q      (w16_q),
  .en_q       (en_q)
);

// File: tb/pcm_tdm_rx_tb.sv
module pcm_tdm_rx_tb_top;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic        net_mode = 1'b0, word16 = 1'b0;
  logic [3:0]  slot_en = 4'h0;
  logic        rx_ready = 1'b1;
  logic        rx_valid, overrun;
  logic [15:0] rx_data;
  logic [1:0]  rx_slot;

  always #2 clk = ~clk;

  pcm_tdm_rx #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .net_mode_i(net_mode), .word16_i(word16), .slot_en_i(slot_en),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .rx_slot_o(rx_slot), .overrun_o(overrun)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: frame tracking from the requirements.
  int due_q[$];
  int data_q[$];
  int slot_q[$];
  bit m_fsprev = 1'b1, m_active = 1'b0, m_net = 1'b0, m_w16 = 1'b0;
  int m_en = 0, m_cnt = 0, m_slot = 0, m_acc = 0;

  function automatic void model_fall(input bit fs, input bit sd);
    int len;
    bit rise;
    rise = fs && !m_fsprev;
    m_fsprev = fs;
    if (rise) begin
      m_active = 1'b1; m_net = net_mode; m_w16 = word16; m_en = int'(slot_en);
      m_slot = 0; m_cnt = 1; m_acc = int'(sd);
    end else if (m_active) begin
      m_acc = m_acc * 2 + int'(sd);
      m_cnt++;
    end
    len = m_w16 ? 16 : 8;
    if (m_active && m_cnt == len) begin
      if (m_net ? ((m_en >> m_slot) & 1) == 1 : m_slot == 0) begin
        due_q.push_back(cyc + SYNC + 1);
        data_q.push_back(m_acc & (m_w16 ? 32'hFFFF : 32'hFF));
        slot_q.push_back(m_slot);
      end
      m_cnt = 0; m_acc = 0; m_slot++;
      if (m_slot >= (m_net ? 4 : 1)) m_active = 1'b0;
    end
  endfunction

  // Expected output register, advanced on every clock.
  bit exp_valid = 1'b0, exp_ovr = 1'b0;
  int exp_data = 0, exp_slot = 0;
  int acc_cnt = 0, ovr_cnt = 0, last_data = 0, last_slot = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      exp_valid = 1'b0; exp_ovr = 1'b0;
    end else begin
      if (exp_valid && rx_ready) begin
        acc_cnt++; last_data = exp_data; last_slot = exp_slot;
      end
      exp_ovr = 1'b0;
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        if (!exp_valid || rx_ready) begin
          exp_valid = 1'b1; exp_data = data_q[0]; exp_slot = slot_q[0];
        end else begin
          exp_ovr = 1'b1; ovr_cnt++;
        end
        void'(due_q.pop_front()); void'(data_q.pop_front()); void'(slot_q.pop_front());
      end else if (rx_ready) begin
        exp_valid = 1'b0;
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rx_valid == exp_valid, "R2", "valid timing", int'(rx_valid), int'(exp_valid));
      if (exp_valid) begin
        chk(int'(rx_data) == exp_data, "R4", "data", int'(rx_data), exp_data);
        chk(int'(rx_slot) == exp_slot, "R7", "slot", int'(rx_slot), exp_slot);
      end
      chk(overrun == exp_ovr, "R10", "overrun pulse", int'(overrun), int'(exp_ovr));
    end
  end

  task automatic bit_out(input bit fs, input bit sd);
    @(negedge clk); bclk = 1'b1; fsync = fs; sdata = sd;
    repeat (3) @(negedge clk);
    @(negedge clk); bclk = 1'b0; model_fall(fs, sd);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input bit net, input bit w16, input logic [3:0] en,
                            input logic [63:0] ws, input int pad);
    int len, ns;
    net_mode = net; word16 = w16; slot_en = en;
    len = w16 ? 16 : 8;
    ns  = net ? 4 : 1;
    for (int s = 0; s < ns; s++)
      for (int b = len - 1; b >= 0; b--)
        bit_out(s == 0 && b == len - 1, ws[63 - 16*s - (15 - b)]);
    for (int p = 0; p < pad; p++) bit_out(1'b0, 1'($urandom));
  endtask

  int a0, o0;

  initial begin
    repeat (4) @(negedge clk);
    chk(rx_valid == 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
    chk(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0 && overrun == 1'b0, "R1", "idle after reset",
        int'({rx_valid, overrun}), 0);
    cmp_on = 1'b1;

    // R3: bits with no frame start produce nothing
    a0 = acc_cnt;
    net_mode = 1'b1; word16 = 1'b0; slot_en = 4'hF;
    for (int i = 0; i < 20; i++) bit_out(1'b0, 1'($urandom));
    chk(acc_cnt == a0, "R3", "words before first frame", acc_cnt - a0, 0);

    // R6, R5: single-word frames with long padding, 8 then 16 bits
    a0 = acc_cnt;
    send_frame(1'b0, 1'b0, 4'hF, {16'h00A5, 48'h0}, 12);
    chk(acc_cnt - a0 == 1, "R6", "one word per frame", acc_cnt - a0, 1);
    chk(last_data == 32'h00A5, "R5", "8-bit word", last_data, 32'h00A5);
    send_frame(1'b0, 1'b1, 4'h0, {16'hBEEF, 48'h0}, 5);
    chk(acc_cnt - a0 == 2, "R6", "mask ignored in single mode", acc_cnt - a0, 2);
    chk(last_data == 32'hBEEF, "R5", "16-bit word", last_data, 32'hBEEF);

    // R7: four 16-bit slots
    a0 = acc_cnt;
    send_frame(1'b1, 1'b1, 4'hF, 64'h1111_2222_3333_C4C4, 3);
    chk(acc_cnt - a0 == 4, "R7", "four slots", acc_cnt - a0, 4);
    chk(last_data == 32'hC4C4 && last_slot == 3, "R7", "last slot word",
        last_data, 32'hC4C4);

    // R8: mask 0101 keeps slots 0 and 2
    a0 = acc_cnt;
    send_frame(1'b1, 1'b0, 4'b0101, {16'h0011, 16'h0022, 16'h0033, 16'h0044}, 3);
    chk(acc_cnt - a0 == 2, "R8", "masked slot count", acc_cnt - a0, 2);
    chk(last_data == 32'h33 && last_slot == 2, "R8", "last kept slot", last_slot, 2);

    // R9: frame restart mid-word discards the partial word
    a0 = acc_cnt;
    net_mode = 1'b1; word16 = 1'b1; slot_en = 4'b0001;
    bit_out(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) bit_out(1'b0, 1'b1);
    send_frame(1'b1, 1'b1, 4'b0001, {16'h5A5A, 48'h0}, 3);
    chk(acc_cnt - a0 == 1, "R9", "restart word count", acc_cnt - a0, 1);
    chk(last_data == 32'h5A5A, "R9", "restart word", last_data, 32'h5A5A);

    // R12: configuration change inside a frame waits for the next frame
    a0 = acc_cnt;
    net_mode = 1'b1; word16 = 1'b0; slot_en = 4'hF;
    for (int i = 31; i >= 0; i--) begin
      if (i == 28) begin net_mode = 1'b0; word16 = 1'b1; slot_en = 4'h0; end
      bit_out(i == 31, 1'(32'h12345678 >> i));
    end
    for (int p = 0; p < 3; p++) bit_out(1'b0, 1'b0);
    chk(acc_cnt - a0 == 4, "R12", "frame kept its settings", acc_cnt - a0, 4);
    chk(last_data == 32'h78 && last_slot == 3, "R12", "last word", last_data, 32'h78);

    // R10, R11: consumer stalled for a whole frame
    a0 = acc_cnt; o0 = ovr_cnt;
    rx_ready = 1'b0;
    send_frame(1'b1, 1'b0, 4'hF, {16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD}, 3);
    chk(ovr_cnt - o0 == 3, "R10", "dropped words", ovr_cnt - o0, 3);
    chk(rx_valid == 1'b1 && rx_data == 16'h00AA, "R11", "held word", int'(rx_data), 32'hAA);
    rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(acc_cnt - a0 == 1, "R11", "released word", acc_cnt - a0, 1);
    chk(rx_valid == 1'b0, "R11", "valid drops after accept", int'(rx_valid), 0);

    chk(due_q.size() == 0, "R2", "pending words", due_q.size(), 0);
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 200000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule